// File: doc/BRIEF.md
# Serial Slave Front-End with Pause Control

This block is the bit-level front end of a serially addressed peripheral. It watches an SPI-style bus (serial clock, active-low select, active-low pause, serial data in) through input synchronizers running on a faster system clock. It frames incoming bits into bytes, MSB first. It checks the first byte of every transaction against a fixed identifier and two device address pins. Every later byte goes to a command layer as a one-cycle strobe. In the other direction it takes a byte from that layer whenever a byte boundary passes and shifts it out on the serial output, with a separate drive-enable that the pad cell uses to tri-state the pin.

The first byte after select falls is the device byte: its upper `BYTE_W-ADDR_W` bits must equal `ID_CODE` and its lower `ADDR_W` bits must equal `dev_addr`. A mismatch leaves the block silent until select rises. A low-going pause input taken while the serial clock is low freezes the transfer in place. A high-going pause input taken while the clock is low lets the transfer continue from the same bit. After reset, no transaction is accepted until select has been seen high and then low.

The controller has seven states. `LNK_LOCKED` is the post-reset lockout and moves to `LNK_IDLE` once select is high. `LNK_IDLE` moves to `LNK_ADDR` when select falls. `LNK_ADDR` moves to `LNK_DATA` on a matching device byte and to `LNK_SKIP` on a mismatch. A pause edge sends `LNK_ADDR` to `LNK_ADDR_HELD` and `LNK_DATA` to `LNK_DATA_HELD`, and a resume edge returns each held state to the state it came from. Select high sends every state except `LNK_LOCKED` back to `LNK_IDLE`.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, no byte strobe, no output drive and no open frame occur until `spi_cs_n` has been high and then gone low; a frame clocked while select is still low from reset is discarded.
- R2: `spi_si` is sampled on rising `spi_sck` edges, MSB first; every 8 payload bits give exactly one single-cycle `rx_valid` pulse with the assembled byte on `rx_data`.
- R3: The first byte of a transaction is the device byte `{ID_CODE, addr}` with the address in bits [1:0]; if it differs from `{ID_CODE, dev_addr}`, no strobe and no output drive occur until select rises.
- R4: `rx_first` is high together with `rx_valid` for the first payload byte of a transaction only.
- R5: `tx_data` is captured at each byte boundary of a matched transaction (pulse on `tx_take`), and its bits appear on `spi_so_data` MSB first, changing only after falling `spi_sck` edges.
- R6: `spi_so_en` is high only during the payload phase of a matched transaction while not paused, and goes low once select is high.
- R7: Select rising in the middle of a byte aborts the transaction: the partial byte is dropped and the bit count restarts, so the next transaction begins with a fresh device byte.
- R8: `spi_hold_n` falling while `spi_sck` is low pauses the transfer: clock edges are ignored, the bit count and shift contents are kept, and `spi_so_en` is low.
- R9: `spi_hold_n` rising while `spi_sck` is low resumes the transfer from the bit where it stopped.
- R10: Edges of `spi_hold_n` that occur while `spi_sck` is high are ignored and do not pause the transfer.
- R11: `frame_open` is high from the matching device byte until select rises, including paused intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low select |
| spi_hold_n | input | 1 | Active-low pause |
| spi_si | input | 1 | Serial data in |
| dev_addr | input | ADDR_W | Device address pins compared with the device byte |
| tx_data | input | BYTE_W | Byte to send next, captured on `tx_take` |
| spi_so_data | output | 1 | Serial data out value |
| spi_so_en | output | 1 | Drive enable for the serial output pad (low = high impedance) |
| rx_valid | output | 1 | One-cycle strobe per received payload byte |
| rx_data | output | BYTE_W | Received payload byte |
| rx_first | output | 1 | Marks the first payload byte of a transaction |
| tx_take | output | 1 | One-cycle pulse when `tx_data` is captured |
| frame_open | output | 1 | A matched transaction is in progress |

## Verification
The bench builds the block with `BYTE_W=8`, `ADDR_W=2`, `SYNC_STAGES=2` and `ID_CODE=6'b101101`. With these values a bus half-period of four system clocks is enough for each pin edge to pass the synchronizers before the next edge arrives. Two synchronizer stages also keep the pipeline short enough that pause edges, aborts inside both the device byte and a payload byte, and data patterns such as all-zero, all-one and alternating bytes are all compared cycle by cycle against a behavioural model. Two different `dev_addr` values and both kinds of device-byte mismatch (identifier and address) are applied.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    // Link controller states.
    typedef enum logic [2:0] {
        LNK_LOCKED,
        LNK_IDLE,
        LNK_ADDR,
        LNK_ADDR_HELD,
        LNK_DATA,
        LNK_DATA_HELD,
        LNK_SKIP
    } lnk_state_e;

    // Bit positions of the bus pins inside the synchronizer vector.
    localparam int unsigned PIN_SCK  = 3;
    localparam int unsigned PIN_CS   = 2;
    localparam int unsigned PIN_HOLD = 1;
    localparam int unsigned PIN_SI   = 0;
    localparam int unsigned PIN_N    = 4;

    // Values the synchronizers hold in reset: select low keeps the lockout
    // armed, pause inactive (high), clock and data low.
    localparam logic [PIN_N-1:0] PIN_RST = 4'b0010;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned      WIDTH   = 4,
    parameter int unsigned      STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // One extra stage so the controller can see edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= RST_VAL;
        end else begin
            last_q <= chain[STAGES-1];
        end
    end

    assign cur_o  = chain[STAGES-1];
    assign prev_o = last_q;

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] byte_o
);

    localparam int unsigned       CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;

    assign byte_o = {sh_q[BYTE_W-2:0], bit_i};
    assign done_o = shift_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (shift_i) begin
            sh_q  <= byte_o;
            cnt_q <= done_o ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              shift_i,
    output logic              bit_o
);

    logic [BYTE_W-1:0] sh_q;
    logic              out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            out_q <= 1'b0;
        end else if (clear_i) begin
            sh_q  <= '0;
            out_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= load_val_i;
        end else if (shift_i) begin
            out_q <= sh_q[BYTE_W-1];
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign bit_o = out_q;

endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
    import spi_hold_pkg::*;
#(
    parameter int unsigned                    BYTE_W      = 8,
    parameter int unsigned                    ADDR_W      = 2,
    parameter int unsigned                    SYNC_STAGES = 2,
    parameter logic [BYTE_W-ADDR_W-1:0]       ID_CODE     = 6'b101101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_hold_n,
    input  logic              spi_si,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              spi_so_data,
    output logic              spi_so_en,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_first,
    output logic              tx_take,
    output logic              frame_open
);

    // ---------------------------------------------------------------
    // Pin synchronizers and edge detection
    // ---------------------------------------------------------------
    logic [PIN_N-1:0] pin_vec;
    logic [PIN_N-1:0] pin_cur;
    logic [PIN_N-1:0] pin_prev;

    assign pin_vec[PIN_SCK]  = spi_sck;
    assign pin_vec[PIN_CS]   = spi_cs_n;
    assign pin_vec[PIN_HOLD] = spi_hold_n;
    assign pin_vec[PIN_SI]   = spi_si;

    spi_pin_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_vec),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    logic cs_hi;
    logic sck_rise;
    logic sck_fall;
    logic hold_fall;
    logic hold_rise;

    assign cs_hi     = pin_cur[PIN_CS];
    assign sck_rise  =  pin_cur[PIN_SCK] && !pin_prev[PIN_SCK];
    assign sck_fall  = !pin_cur[PIN_SCK] &&  pin_prev[PIN_SCK];
    // Pause edges count only while the serial clock is low.
    assign hold_fall = !pin_cur[PIN_HOLD] &&  pin_prev[PIN_HOLD] && !pin_cur[PIN_SCK];
    assign hold_rise =  pin_cur[PIN_HOLD] && !pin_prev[PIN_HOLD] && !pin_cur[PIN_SCK];

    // ---------------------------------------------------------------
    // State
    // ---------------------------------------------------------------
    lnk_state_e state_q;
    lnk_state_e state_d;

    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              addr_match;
    logic              rx_shift_en;
    logic              tx_shift_en;
    logic              tx_load;
    logic              first_pend_q;

    assign addr_match = (byte_val == {ID_CODE, dev_addr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LNK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_LOCKED: begin
                if (cs_hi) state_d = LNK_IDLE;
            end
            LNK_IDLE: begin
                if (!cs_hi) state_d = LNK_ADDR;
            end
            LNK_ADDR: begin
                if (cs_hi)          state_d = LNK_IDLE;
                else if (hold_fall) state_d = LNK_ADDR_HELD;
                else if (byte_done) state_d = addr_match ? LNK_DATA : LNK_SKIP;
            end
            LNK_ADDR_HELD: begin
                if (cs_hi)          state_d = LNK_IDLE;
                else if (hold_rise) state_d = LNK_ADDR;
            end
            LNK_DATA: begin
                if (cs_hi)          state_d = LNK_IDLE;
                else if (hold_fall) state_d = LNK_DATA_HELD;
            end
            LNK_DATA_HELD: begin
                if (cs_hi)          state_d = LNK_IDLE;
                else if (hold_rise) state_d = LNK_DATA;
            end
            LNK_SKIP: begin
                if (cs_hi) state_d = LNK_IDLE;
            end
            default: state_d = LNK_LOCKED;
        endcase
    end

    // ---------------------------------------------------------------
    // Shifters
    // ---------------------------------------------------------------
    assign rx_shift_en = sck_rise && !cs_hi &&
                         ((state_q == LNK_ADDR) || (state_q == LNK_DATA));
    assign tx_shift_en = sck_fall && !cs_hi && !hold_fall && (state_q == LNK_DATA);
    assign tx_load     = byte_done &&
                         ((state_q == LNK_DATA) || ((state_q == LNK_ADDR) && addr_match));

    spi_rx_shift #(
        .BYTE_W (BYTE_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cs_hi),
        .shift_i (rx_shift_en),
        .bit_i   (pin_cur[PIN_SI]),
        .done_o  (byte_done),
        .byte_o  (byte_val)
    );

    spi_tx_shift #(
        .BYTE_W (BYTE_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (cs_hi),
        .load_i     (tx_load),
        .load_val_i (tx_data),
        .shift_i    (tx_shift_en),
        .bit_o      (spi_so_data)
    );

    // ---------------------------------------------------------------
    // Outputs to the command layer
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid     <= 1'b0;
            rx_data      <= '0;
            rx_first     <= 1'b0;
            tx_take      <= 1'b0;
            first_pend_q <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_first <= 1'b0;
            tx_take  <= tx_load;
            if (byte_done && (state_q == LNK_DATA)) begin
                rx_valid     <= 1'b1;
                rx_data      <= byte_val;
                rx_first     <= first_pend_q;
                first_pend_q <= 1'b0;
            end
            if (byte_done && (state_q == LNK_ADDR) && addr_match) begin
                first_pend_q <= 1'b1;
            end
        end
    end

    assign spi_so_en  = (state_q == LNK_DATA);
    assign frame_open = (state_q == LNK_DATA) || (state_q == LNK_DATA_HELD);

endmodule

// File: rtl/spi_hold_slave_chk.sv
module spi_hold_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_hi,
    input logic sck_fall,
    input logic spi_so_en,
    input logic spi_so_data,
    input logic rx_valid,
    input logic rx_first,
    input logic tx_take,
    input logic frame_open
);

    // R2: a byte strobe never lasts two cycles
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: the first-byte mark only travels with a strobe
    a_r4_first_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_first |-> rx_valid);

    // R5: the serial output moves only after a falling clock edge or a deselect
    a_r5_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_so_en && !sck_fall && !cs_hi) |=> $stable(spi_so_data));

    // R6: deselect releases the output drive
    a_r6_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !spi_so_en);

    // R8: a paused frame produces neither strobes nor captures
    a_r8_quiet_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_open && !spi_so_en) |-> (!rx_valid && !tx_take));

    // R11: a frame opens only together with the first capture of send data
    a_r11_open_with_take: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_open) |-> tx_take);

endmodule

bind spi_hold_slave spi_hold_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_hi       (cs_hi),
    .sck_fall    (sck_fall),
    .spi_so_en   (spi_so_en),
    .spi_so_data (spi_so_data),
    .rx_valid    (rx_valid),
    .rx_first    (rx_first),
    .tx_take     (tx_take),
    .frame_open  (frame_open)
);

// File: tb/sim_spi_hold_slave.sv
`timescale 1ns/1ps
module sim_spi_hold_slave;

    localparam int unsigned BW = 8;
    localparam int unsigned AW = 2;
    localparam int unsigned SS = 2;
    localparam logic [5:0]  IDC = 6'b101101;

    localparam int M_LOCK = 0, M_IDLE = 1, M_ADDR = 2, M_ADDRH = 3,
                   M_DATA = 4, M_DATAH = 5, M_SKIP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          sck = 1'b0, cs_n = 1'b0, hold_n = 1'b1, si = 1'b0;
    logic [AW-1:0] dev_addr = 2'b01;
    logic [BW-1:0] tx_data = 8'h5A;

    logic          so_data, so_en, rx_valid, rx_first, tx_take, frame_open;
    logic [BW-1:0] rx_data;

    spi_hold_slave #(
        .BYTE_W (BW), .ADDR_W (AW), .SYNC_STAGES (SS), .ID_CODE (IDC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .spi_sck (sck), .spi_cs_n (cs_n),
        .spi_hold_n (hold_n), .spi_si (si), .dev_addr (dev_addr),
        .tx_data (tx_data), .spi_so_data (so_data), .spi_so_en (so_en),
        .rx_valid (rx_valid), .rx_data (rx_data), .rx_first (rx_first),
        .tx_take (tx_take), .frame_open (frame_open)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            st = M_LOCK;
    int            mcnt = 0;
    logic [7:0]    mrx = '0, mtx = '0, e_data = '0;
    logic          mq = 1'b0, mpend = 1'b0;
    logic          e_valid = 1'b0, e_first = 1'b0, e_take = 1'b0;
    logic [3:0]    hq[$];

    initial begin
        for (int i = 0; i <= int'(SS); i++) hq.push_front(4'b0010);
    end

    always @(posedge clk) begin : model
        logic [3:0] v, pv;
        logic rise, fall, hf, hr;
        logic [7:0] nb;
        if (rst_n) begin
            v  = hq[SS-1];
            pv = hq[SS];
            rise = v[3] && !pv[3];
            fall = !v[3] && pv[3];
            hf = !v[1] && pv[1] && !v[3];
            hr = v[1] && !pv[1] && !v[3];
            e_valid = 1'b0; e_first = 1'b0; e_take = 1'b0;
            if (v[2]) begin
                st = M_IDLE; mcnt = 0; mrx = '0; mtx = '0; mq = 1'b0;
            end else begin
                case (st)
                    M_IDLE: st = M_ADDR;
                    M_ADDR: begin
                        if (hf) st = M_ADDRH;
                        else if (rise) begin
                            nb = {mrx[6:0], v[0]}; mrx = nb;
                            if (mcnt == 7) begin
                                mcnt = 0;
                                if (nb == {IDC, dev_addr}) begin
                                    st = M_DATA; mtx = tx_data; e_take = 1'b1; mpend = 1'b1;
                                end else st = M_SKIP;
                            end else mcnt++;
                        end
                    end
                    M_ADDRH: if (hr) st = M_ADDR;
                    M_DATA: begin
                        if (hf) st = M_DATAH;
                        else if (rise) begin
                            nb = {mrx[6:0], v[0]}; mrx = nb;
                            if (mcnt == 7) begin
                                mcnt = 0; e_valid = 1'b1; e_data = nb;
                                e_first = mpend; mpend = 1'b0;
                                mtx = tx_data; e_take = 1'b1;
                            end else mcnt++;
                        end else if (fall) begin
                            mq = mtx[7]; mtx = {mtx[6:0], 1'b0};
                        end
                    end
                    M_DATAH: if (hr) st = M_DATA;
                    default: ;
                endcase
            end
            hq.push_front({sck, cs_n, hold_n, si});
            void'(hq.pop_back());
        end
    end

    // ---------------- per-cycle compare and port bookkeeping ----------------
    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] take_q[$];
    int n_first = 0, oe_seen = 0, open_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(rx_valid == e_valid, "R2 rx_valid", rx_valid, e_valid);
            if (e_valid) chk(rx_data == e_data, "R2 rx_data", rx_data, e_data);
            chk(rx_first == e_first, "R4 rx_first", rx_first, e_first);
            chk(tx_take == e_take, "R5 tx_take", tx_take, e_take);
            chk(so_en == (st == M_DATA), "R6 so_en", so_en, st == M_DATA);
            chk(frame_open == (st == M_DATA || st == M_DATAH), "R11 frame_open",
                frame_open, st == M_DATA || st == M_DATAH);
            if (so_en && st == M_DATA) chk(so_data == mq, "R5 so_data", so_data, mq);
            if (rx_valid) got_q.push_back(rx_data);
            if (rx_first) n_first++;
            if (so_en) oe_seen++;
            if (frame_open) open_seen++;
            if (tx_take) begin
                take_q.push_back(tx_data);
                tx_data = tx_data + 8'h3B;
            end
        end
    end

    // ---------------- bus tasks (called at a falling clk edge) ----------------
    task automatic sbit(input logic b, output logic r);
        si = b;
        repeat (4) @(negedge clk);
        r = so_data;
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic sbit_h(input logic b, input logic hv);
        si = b;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        hold_n = hv;
        repeat (2) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic x;
            sbit(b[i], x);
            r[i] = x;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        take_q.delete();
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Device byte then n payload bytes; reads checked when do_read is set.
    task automatic frame(input logic [7:0] devb, input int n, input logic [7:0] base,
                         input bit do_read, input bit keep);
        logic [7:0] r, p;
        sbyte(devb, r);
        for (int i = 0; i < n; i++) begin
            p = base + 8'(i * 8'h4D);
            if (keep) exp_q.push_back(p);
            sbyte(p, r);
            if (do_read && take_q.size() > i)
                chk(r == take_q[i], "R5 read byte", r, take_q[i]);
        end
    endtask

    task automatic cmp_bytes(input string tag);
        chk(got_q.size() == exp_q.size(), tag, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] good, r;
        logic x;
        good = {IDC, 2'b01};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(so_en == 1'b0, "R1 reset so_en", so_en, 0);
        chk(frame_open == 1'b0, "R1 reset frame_open", frame_open, 0);
        chk(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: select still low since reset -> whole frame ignored
        frame(good, 2, 8'h11, 1'b0, 1'b0);
        chk(got_q.size() == 0, "R1 lockout bytes", got_q.size(), 0);
        chk(open_seen == 0, "R1 lockout frame", open_seen, 0);
        desel();

        // R2 R4 R5 R11: normal transaction
        n_first = 0;
        sel();
        frame(good, 3, 8'hA5, 1'b1, 1'b1);
        chk(frame_open == 1'b1, "R11 open before deselect", frame_open, 1);
        desel();
        chk(frame_open == 1'b0, "R11 closed after deselect", frame_open, 0);
        cmp_bytes("R2 normal bytes");
        chk(n_first == 1, "R4 first count", n_first, 1);

        // R2 R3: other address pins, boundary data patterns
        dev_addr = 2'b10;
        good = {IDC, 2'b10};
        sel();
        sbyte(good, r);
        sbyte(8'h00, r); exp_q.push_back(8'h00);
        sbyte(8'hFF, r); exp_q.push_back(8'hFF);
        sbyte(8'h81, r); exp_q.push_back(8'h81);
        desel();
        cmp_bytes("R3 match on new address");

        // R3: address bits and identifier bits mismatched
        oe_seen = 0;
        sel(); frame({IDC, 2'b01}, 2, 8'h3C, 1'b0, 1'b0); desel();
        sel(); frame({IDC ^ 6'b000100, 2'b10}, 2, 8'h3C, 1'b0, 1'b0); desel();
        chk(got_q.size() == 0, "R3 mismatch bytes", got_q.size(), 0);
        chk(oe_seen == 0, "R3 mismatch drive", oe_seen, 0);
        got_q.delete();

        // R7: abort inside payload byte, then inside device byte
        sel(); sbyte(good, r);
        sbit(1'b1, x); sbit(1'b0, x); sbit(1'b1, x);
        desel();
        sel(); sbit(1'b1, x); sbit(1'b1, x); sbit(1'b0, x); sbit(1'b1, x); sbit(1'b0, x);
        desel();
        sel(); frame(good, 2, 8'h6E, 1'b1, 1'b1); desel();
        cmp_bytes("R7 abort then fresh frame");

        // R8 R9: pause inside a payload byte
        sel(); sbyte(good, r);
        for (int i = 7; i >= 4; i--) sbit(r_bit(8'hC6, i), x);
        hold_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(so_en == 1'b0, "R8 drive off while paused", so_en, 0);
        chk(frame_open == 1'b1, "R8 frame kept while paused", frame_open, 1);
        si = 1'b1;
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; repeat (4) @(negedge clk);
            sck = 1'b0; repeat (4) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(so_en == 1'b1, "R9 drive back after resume", so_en, 1);
        for (int i = 3; i >= 0; i--) sbit(r_bit(8'hC6, i), x);
        sbyte(8'h2B, r);
        desel();
        exp_q.push_back(8'hC6); exp_q.push_back(8'h2B);
        cmp_bytes("R8 R9 paused payload byte intact");

        // R8 R9: pause inside the device byte
        sel();
        for (int i = 7; i >= 5; i--) sbit(good[i], x);
        hold_n = 1'b0; repeat (4) @(negedge clk);
        si = 1'b0;
        sck = 1'b1; repeat (4) @(negedge clk);
        sck = 1'b0; repeat (4) @(negedge clk);
        hold_n = 1'b1; repeat (4) @(negedge clk);
        for (int i = 4; i >= 0; i--) sbit(good[i], x);
        sbyte(8'h97, r);
        desel();
        exp_q.push_back(8'h97);
        cmp_bytes("R8 R9 paused device byte");

        // R10: pause edges while the clock is high are ignored
        sel(); sbyte(good, r);
        sbit_h(1'b0, 1'b0);
        for (int i = 6; i >= 1; i--) sbit(r_bit(8'h5C, i), x);
        chk(so_en == 1'b1, "R10 no pause on high-clock edge", so_en, 1);
        sbit_h(1'b0, 1'b1);
        sbyte(8'hE3, r);
        desel();
        exp_q.push_back(8'h5C); exp_q.push_back(8'hE3);
        cmp_bytes("R10 bytes with ignored pause edges");

        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    function automatic logic r_bit(input logic [7:0] b, input int i);
        return b[i];
    endfunction

endmodule